// File: doc/BRIEF.md
# Five-Slot Dispatch Group Hazard Checker

This block decides, one candidate instruction at a time, whether the instruction may be placed into the dispatch group currently being assembled. A group has five slots. The last slot is kept for a branch. Some instructions must open a group. Condition-register operations may only sit early in a group. An instruction the decoder splits into two operations takes two slots. The checker also watches for two structural hazards inside a group: a branch through the count register after an instruction in the same group has written that register, and a load whose address overlaps a store already placed in the group. The address comparison itself is done by a neighbouring block, which reports its result on a conflict input.

A scheduler presents the candidate's unit class and attribute flags and reads a combinational verdict. The verdict is one of three values: clear, stall (the candidate cannot join this group), or no-op (the group needs filler before this candidate). When the scheduler commits the candidate it pulses the issue input. When it lets a cycle pass empty it pulses the advance input. Either event can close the group. A close is reported on a one-cycle group-end output and returns the internal state to an empty group. A request that makes no sense is flagged and changes no state: issue together with advance, or issue of a candidate that received a stall verdict.

Top module: `dg_hazard_checker`

## Requirements
- R1: After reset the group is empty. `verdict_o` encodes 0 = clear, 1 = stall, 2 = no-op. `unit_i` encodes 0 fixed-point, 1 load/store, 2 floating-point, 3 vector ALU, 4 vector permute, 5 condition-register, 6 branch, 7 pseudo. In an empty group a first-only fixed-point candidate is clear.
- R2: A candidate flagged first-only or single gets stall whenever one or more slots are already taken.
- R3: A cracked candidate gets stall when more than two slots are taken. When issued it takes two slots.
- R4: A fixed-point, load/store, floating-point or vector candidate gets stall when four slots are taken. A branch at that point is clear.
- R5: A condition-register candidate gets stall once two or more slots are taken.
- R6: Issuing a branch or a single instruction closes the group. `group_end_o` is high in the cycle of that issue, and the next candidate sees an empty group.
- R7: After an issued counter-writing instruction, a branch-via-counter candidate in the same group gets no-op. Once the group closes, the same candidate is clear.
- R8: A load with `conflict_i` high gets no-op only if the group already holds at least one issued store. With no store recorded, `conflict_i` has no effect.
- R9: A pseudo candidate is always clear, and issuing it changes no state.
- R10: An advance adds one slot. The advance that reaches five slots raises `group_end_o` and clears the slot count, the counter-written mark and the store record.
- R11: `err_o` is high when issue and advance are both high, or when issue is high while the verdict is stall. In that cycle no state changes and `group_end_o` stays low.
- R12: Stall takes priority over no-op when both apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| unit_i | input | 3 | Candidate unit class |
| first_only_i | input | 1 | Candidate must open a group |
| single_i | input | 1 | Candidate opens and closes a group |
| cracked_i | input | 1 | Candidate takes two slots |
| is_load_i | input | 1 | Candidate reads memory |
| is_store_i | input | 1 | Candidate writes memory |
| sets_ctr_i | input | 1 | Candidate writes the count register |
| br_via_ctr_i | input | 1 | Candidate branches through the count register |
| conflict_i | input | 1 | Neighbour reports load/store address overlap |
| issue_i | input | 1 | Commit the candidate into the group |
| advance_i | input | 1 | Let one cycle pass with no issue |
| verdict_o | output | 2 | Clear / stall / no-op |
| group_end_o | output | 1 | Group closes this cycle |
| err_o | output | 1 | Illegal request, ignored |

## Verification
The slot count, the counter-written mark and the store record cannot be read directly. A fault in any of them shows up in the verdict that the next suitable candidate receives. A wrong count changes the stall verdicts for first-only, condition-register and slot-five candidates, and it moves the cycle in which `group_end_o` rises. A stale mark or store record shows as a no-op verdict right after a group closes. Because a reference model is compared on every clock, such a fault is caught in the first cycle in which a candidate probes the corrupted state. That is at most a few cycles after the fault during the directed sequences.

// File: rtl/dg_pkg.sv
package dg_pkg;
   typedef enum logic [2:0] {
      U_FIX    = 3'd0,
      U_LDST   = 3'd1,
      U_FLT    = 3'd2,
      U_VALU   = 3'd3,
      U_VPERM  = 3'd4,
      U_CREG   = 3'd5,
      U_BR     = 3'd6,
      U_PSEUDO = 3'd7
   } unit_e;

   typedef enum logic [1:0] {
      V_CLEAR = 2'd0,
      V_STALL = 2'd1,
      V_NOP   = 2'd2
   } verdict_e;
endpackage

// File: rtl/dg_rules.sv
module dg_rules
   import dg_pkg::*;
#(
   parameter int GROUP_SLOTS = 5,
   parameter int CR_WINDOW   = 2,
   parameter int CNT_W       = 3
) (
   input  unit_e              unit,
   input  logic               first_only,
   input  logic               single,
   input  logic               cracked,
   input  logic               is_load,
   input  logic               br_via_ctr,
   input  logic               conflict,
   input  logic [CNT_W-1:0]   cnt,
   input  logic               ctr_set,
   input  logic               any_store,
   output verdict_e           verdict
);
   localparam logic [CNT_W-1:0] BR_SLOT   = CNT_W'(GROUP_SLOTS - 1);
   localparam logic [CNT_W-1:0] CRACK_MAX = CNT_W'(GROUP_SLOTS - 3);
   localparam logic [CNT_W-1:0] CR_LIM    = CNT_W'(CR_WINDOW);

   logic open_slot;
   logic slot_bad;

   always_comb begin
      open_slot = (cnt == '0);
      case (unit)
         U_CREG:   slot_bad = (cnt >= CR_LIM);
         U_BR:     slot_bad = 1'b0;
         U_PSEUDO: slot_bad = 1'b0;
         default:  slot_bad = (cnt == BR_SLOT);
      endcase
   end

   always_comb begin
      if (unit == U_PSEUDO)
         verdict = V_CLEAR;
      else if (!open_slot && (first_only || single))
         verdict = V_STALL;
      else if (cracked && (cnt > CRACK_MAX))
         verdict = V_STALL;
      else if (slot_bad)
         verdict = V_STALL;
      else if (ctr_set && br_via_ctr)
         verdict = V_NOP;
      else if (is_load && any_store && conflict)
         verdict = V_NOP;
      else
         verdict = V_CLEAR;
   end
endmodule

// File: rtl/dg_state.sv
module dg_state
   import dg_pkg::*;
#(
   parameter int GROUP_SLOTS = 5,
   parameter int STORE_TRACK = 4,
   parameter int CNT_W       = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               do_issue,
   input  logic               do_adv,
   input  unit_e              unit,
   input  logic               single,
   input  logic               cracked,
   input  logic               is_store,
   input  logic               sets_ctr,
   output logic [CNT_W-1:0]   cnt_q,
   output logic               ctr_q,
   output logic               any_store,
   output logic               close
);
   localparam logic [CNT_W-1:0] BR_SLOT = CNT_W'(GROUP_SLOTS - 1);
   localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(GROUP_SLOTS);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      base  = ((unit == U_BR) || single) ? BR_SLOT : cnt_q;
      nxt   = do_issue ? (base + ONE + {{(CNT_W-1){1'b0}}, cracked})
                       : (cnt_q + ONE);
      close = (do_issue || do_adv) && (nxt >= LIMIT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ctr_q <= 1'b0;
      end else if (close) begin
         cnt_q <= '0;
         ctr_q <= 1'b0;
      end else if (do_issue) begin
         cnt_q <= nxt;
         ctr_q <= ctr_q | sets_ctr;
      end else if (do_adv) begin
         cnt_q <= nxt;
      end
   end

   generate
      if (STORE_TRACK > 0) begin : g_track
         localparam int ST_W = $clog2(STORE_TRACK + 1);
         localparam logic [ST_W-1:0] ST_FULL = ST_W'(STORE_TRACK);
         logic [ST_W-1:0] st_q;
         always_ff @(posedge clk) begin
            if (!rst_n || close)
               st_q <= '0;
            else if (do_issue && is_store && (st_q != ST_FULL))
               st_q <= st_q + 1'b1;
         end
         assign any_store = (st_q != '0);
      end else begin : g_none
         assign any_store = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dg_hazard_checker.sv
module dg_hazard_checker
   import dg_pkg::*;
#(
   parameter int GROUP_SLOTS = 5,
   parameter int CR_WINDOW   = 2,
   parameter int STORE_TRACK = 4
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] unit_i,
   input  logic       first_only_i,
   input  logic       single_i,
   input  logic       cracked_i,
   input  logic       is_load_i,
   input  logic       is_store_i,
   input  logic       sets_ctr_i,
   input  logic       br_via_ctr_i,
   input  logic       conflict_i,
   input  logic       issue_i,
   input  logic       advance_i,
   output logic [1:0] verdict_o,
   output logic       group_end_o,
   output logic       err_o
);
   localparam int CNT_W = $clog2(GROUP_SLOTS + 2);

   generate
      if (GROUP_SLOTS < 4) begin : g_bad_slots
         $error("GROUP_SLOTS must be at least 4");
      end
      if (CR_WINDOW < 1 || CR_WINDOW >= GROUP_SLOTS) begin : g_bad_cr
         $error("CR_WINDOW must lie in 1..GROUP_SLOTS-1");
      end
      if (STORE_TRACK < 0) begin : g_bad_st
         $error("STORE_TRACK must not be negative");
      end
   endgenerate

   unit_e            unit;
   verdict_e         verdict;
   logic [CNT_W-1:0] cnt_q;
   logic             ctr_q;
   logic             st_any;
   logic             close;
   logic             do_issue;
   logic             do_adv;

   assign unit     = unit_e'(unit_i);
   assign err_o    = issue_i && (advance_i || (verdict == V_STALL));
   assign do_issue = issue_i && !err_o && (unit != U_PSEUDO);
   assign do_adv   = advance_i && !err_o;

   dg_rules #(
      .GROUP_SLOTS (GROUP_SLOTS),
      .CR_WINDOW   (CR_WINDOW),
      .CNT_W       (CNT_W)
   ) u_rules (
      .unit       (unit),
      .first_only (first_only_i),
      .single     (single_i),
      .cracked    (cracked_i),
      .is_load    (is_load_i),
      .br_via_ctr (br_via_ctr_i),
      .conflict   (conflict_i),
      .cnt        (cnt_q),
      .ctr_set    (ctr_q),
      .any_store  (st_any),
      .verdict    (verdict)
   );

   dg_state #(
      .GROUP_SLOTS (GROUP_SLOTS),
      .STORE_TRACK (STORE_TRACK),
      .CNT_W       (CNT_W)
   ) u_state (
      .clk       (clk_i),
      .rst_n     (rst_ni),
      .do_issue  (do_issue),
      .do_adv    (do_adv),
      .unit      (unit),
      .single    (single_i),
      .cracked   (cracked_i),
      .is_store  (is_store_i),
      .sets_ctr  (sets_ctr_i),
      .cnt_q     (cnt_q),
      .ctr_q     (ctr_q),
      .any_store (st_any),
      .close     (close)
   );

   assign verdict_o   = verdict;
   assign group_end_o = close;
endmodule

// File: rtl/dg_checker.sv
module dg_checker #(
   parameter int GROUP_SLOTS = 5,
   parameter int CNT_W       = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       unit,
   input logic             first_only,
   input logic             single,
   input logic             br_via_ctr,
   input logic             issue,
   input logic             advance,
   input logic [1:0]       verdict,
   input logic             group_end,
   input logic             err,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ctr_q,
   input logic             st_any
);
   // R10
   always @(posedge clk) begin
      if (rst_n) begin
         cnt_range_chk: assert (cnt_q < CNT_W'(GROUP_SLOTS))
            else $error("slot count out of range");
      end
   end

   // R6
   grp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      group_end |=> (cnt_q == '0) && !ctr_q && !st_any);

   // R11
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> $stable(cnt_q) && $stable(ctr_q) && $stable(st_any));

   // R11
   err_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !group_end);

   // R9
   pseudo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !advance && unit == 3'd7) |=> $stable(cnt_q) && $stable(ctr_q));

   // R2
   late_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q != '0) && (first_only || single) && unit != 3'd7) |-> verdict == 2'd1);

   // R7
   ctr_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_q && br_via_ctr && unit != 3'd7 && verdict != 2'd1) |-> verdict == 2'd2);
endmodule

bind dg_hazard_checker dg_checker #(
   .GROUP_SLOTS (GROUP_SLOTS),
   .CNT_W       (CNT_W)
) u_chk (
   .clk        (clk_i),
   .rst_n      (rst_ni),
   .unit       (unit_i),
   .first_only (first_only_i),
   .single     (single_i),
   .br_via_ctr (br_via_ctr_i),
   .issue      (issue_i),
   .advance    (advance_i),
   .verdict    (verdict_o),
   .group_end  (group_end_o),
   .err        (err_o),
   .cnt_q      (cnt_q),
   .ctr_q      (ctr_q),
   .st_any     (st_any)
);

// File: tb/tb_dg_hazard_checker.sv
module tb_dg_hazard_checker;
   localparam int PER = 10;
   // flag vector bit order: first_only, single, cracked, load, store, sets_ctr, br_via_ctr
   localparam logic [6:0] F_NONE = 7'b0000000;
   localparam logic [6:0] F_FO   = 7'b1000000;
   localparam logic [6:0] F_SG   = 7'b0100000;
   localparam logic [6:0] F_CR   = 7'b0010000;
   localparam logic [6:0] F_LD   = 7'b0001000;
   localparam logic [6:0] F_ST   = 7'b0000100;
   localparam logic [6:0] F_SC   = 7'b0000010;
   localparam logic [6:0] F_BV   = 7'b0000001;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] unit = 3'd0;
   logic [6:0] flg = '0;
   logic       conflict = 1'b0;
   logic       issue = 1'b0;
   logic       advance = 1'b0;
   logic [1:0] verdict;
   logic       group_end;
   logic       err;

   int vectors = 0;
   int fails = 0;
   int m_cnt = 0;
   int m_ctr = 0;
   int m_st = 0;
   string cur_req = "R1";
   bit finished = 1'b0;

   always #(PER/2) clk = ~clk;

   dg_hazard_checker dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .unit_i       (unit),
      .first_only_i (flg[6]),
      .single_i     (flg[5]),
      .cracked_i    (flg[4]),
      .is_load_i    (flg[3]),
      .is_store_i   (flg[2]),
      .sets_ctr_i   (flg[1]),
      .br_via_ctr_i (flg[0]),
      .conflict_i   (conflict),
      .issue_i      (issue),
      .advance_i    (advance),
      .verdict_o    (verdict),
      .group_end_o  (group_end),
      .err_o        (err)
   );

   function automatic int model_verdict(int u, logic [6:0] f, bit cf);
      if (u == 7) return 0;
      if (m_cnt != 0 && (f[6] || f[5])) return 1;
      if (f[4] && m_cnt > 2) return 1;
      if (u <= 4 && m_cnt == 4) return 1;
      if (u == 5 && m_cnt >= 2) return 1;
      if (m_ctr != 0 && f[0]) return 2;
      if (f[3] && m_st > 0 && cf) return 2;
      return 0;
   endfunction

   task automatic check(string what, int got, int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
      end
   endtask

   task automatic apply(int u, logic [6:0] f, bit cf, bit iss, bit adv);
      int ev;
      int ee;
      int eg;
      int n;
      @(negedge clk);
      unit = 3'(u);
      flg = f;
      conflict = cf;
      issue = iss;
      advance = adv;
      ev = model_verdict(u, f, cf);
      ee = (iss && (adv || ev == 1)) ? 1 : 0;
      eg = 0;
      n = m_cnt;
      if (ee == 0) begin
         if (iss && u != 7) begin
            n = ((u == 6) || f[5]) ? 4 : m_cnt;
            n = n + 1 + int'(f[4]);
         end else if (adv) begin
            n = m_cnt + 1;
         end
         if ((iss && u != 7) || adv) eg = (n >= 5) ? 1 : 0;
      end
      #(PER/2 - 2);
      check("verdict", int'(verdict), ev);
      check("group_end", int'(group_end), eg);
      check("err", int'(err), ee);
      @(posedge clk);
      if (ee == 0) begin
         if (eg != 0) begin
            m_cnt = 0; m_ctr = 0; m_st = 0;
         end else if (iss && u != 7) begin
            m_cnt = n;
            if (f[1]) m_ctr = 1;
            if (f[2] && m_st < 4) m_st++;
         end else if (adv) begin
            m_cnt = n;
         end
      end
   endtask

   task automatic probe(int u, logic [6:0] f, bit cf);
      apply(u, f, cf, 1'b0, 1'b0);
   endtask

   task automatic go(int u, logic [6:0] f);
      apply(u, f, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic adv1();
      apply(0, F_NONE, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R1";
      probe(0, F_FO, 1'b0);
      probe(6, F_NONE, 1'b0);

      cur_req = "R2";
      go(0, F_NONE);
      probe(0, F_FO, 1'b0);
      probe(1, F_SG, 1'b0);
      probe(7, F_FO, 1'b0);

      cur_req = "R10";
      adv1(); adv1(); adv1();
      adv1();
      probe(0, F_FO, 1'b0);

      cur_req = "R4";
      adv1(); adv1(); adv1(); adv1();
      for (int u = 0; u < 5; u++) probe(u, F_NONE, 1'b0);
      probe(6, F_NONE, 1'b0);
      cur_req = "R6";
      go(6, F_NONE);
      probe(0, F_FO, 1'b0);
      go(0, F_SG);
      probe(0, F_FO, 1'b0);

      cur_req = "R5";
      probe(5, F_NONE, 1'b0);
      go(0, F_NONE);
      probe(5, F_NONE, 1'b0);
      go(0, F_NONE);
      probe(5, F_NONE, 1'b0);
      go(6, F_NONE);

      cur_req = "R3";
      go(0, F_NONE); go(0, F_NONE);
      go(1, F_CR);
      probe(0, F_NONE, 1'b0);
      probe(6, F_NONE, 1'b0);
      go(6, F_NONE);
      go(0, F_NONE); go(0, F_NONE); go(0, F_NONE);
      probe(1, F_CR, 1'b0);
      adv1(); adv1();

      cur_req = "R7";
      go(0, F_SC);
      probe(6, F_BV, 1'b0);
      adv1(); adv1(); adv1(); adv1();
      probe(6, F_BV, 1'b0);

      cur_req = "R8";
      probe(1, F_LD, 1'b1);
      go(1, F_ST);
      probe(1, F_LD, 1'b1);
      probe(1, F_LD, 1'b0);
      adv1(); adv1(); adv1(); adv1();
      probe(1, F_LD, 1'b1);

      cur_req = "R9";
      go(0, F_NONE);
      probe(7, F_FO | F_SG, 1'b0);
      go(7, F_CR | F_SC | F_SG);
      go(7, F_NONE);
      probe(5, F_NONE, 1'b0);
      probe(6, F_BV, 1'b0);
      adv1(); adv1(); adv1();
      probe(0, F_FO, 1'b0);

      cur_req = "R11";
      go(0, F_NONE);
      apply(0, F_NONE, 1'b0, 1'b1, 1'b1);
      go(0, F_FO);
      probe(5, F_NONE, 1'b0);
      adv1(); adv1(); adv1();
      probe(0, F_FO, 1'b0);

      cur_req = "R12";
      go(0, F_SC);
      probe(0, F_FO | F_BV, 1'b0);
      go(1, F_ST);
      probe(1, F_SG | F_LD, 1'b1);
      adv1();
      probe(0, F_BV, 1'b0);
      adv1();

      cur_req = "mixed";
      for (int i = 0; i < 4000; i++) begin
         int u;
         logic [6:0] f;
         bit cf;
         bit iss;
         bit adv;
         int r;
         u = int'($urandom % 8);
         f = F_NONE;
         for (int b = 0; b < 7; b++) if ($urandom % 6 == 0) f[b] = 1'b1;
         cf = ($urandom % 2) == 0;
         r = int'($urandom % 20);
         iss = (r < 12);
         adv = (r >= 12 && r < 18) || (r == 19);
         if (iss && !adv && model_verdict(u, f, cf) == 1 && ($urandom % 8 != 0)) iss = 1'b0;
         apply(u, f, cf, iss, adv);
      end

      finish_run();
   end
endmodule